// File: doc/BRIEF.md
# Mesh Switch Misroute and Hop-Count Checker

This block sits next to the route logic of one five-port mesh switch. The switch has four neighbour ports and one port to the local processing element. On every header flit it reads the source and destination coordinates carried in the flit. It then decides whether a packet routed X-first, then Y, could ever arrive at this switch through the port it came in on. Packets that fail this test are reported as misrouted.

The block also advances the hop-count field carried in the header by one and reports an overflow when that field runs out. The hop count catches packets that bounce between two switches while still looking geometrically plausible. On either error, one cycle after the header, the block raises a single-cycle alarm. The alarm carries the code of the arrival port, which points at the neighbour that most likely misbehaved. The switch writes the updated hop field back into the forwarded header.

Top module: `misroute_hop_checker`

## Requirements
- R1: While rst_ni is low, and until the first header is accepted after reset, every output is zero.
- R2: Header field layout (with COORD_W=4 and HOP_W=6):
  - destination x is hdr_i[3:0] and destination y is hdr_i[7:4];
  - source x is hdr_i[11:8] and source y is hdr_i[15:12];
  - the hop count is hdr_i[21:16].
  
  One cycle after a header cycle, hop_valid_o is 1 and hop_o is the incoming hop count plus one.
- R3: When the incoming hop count is all ones, one cycle later overflow_o is 1, hop_o stays at all ones, and an alarm is raised, whether or not the packet is on its path.
- R4: A header arriving on the local port (code 4) is legal only when its source coordinates equal the switch's own coordinates (here_x_i, here_y_i). Otherwise distract_o is set one cycle later.
- R5: The X phase is legal only under all of these conditions:
  - the switch is in the source row;
  - the switch is not the source column;
  - the switch lies strictly past the source x and no further than the destination x;
  - for a destination to the east (larger x), the header entered on the west port (code 3);
  - for a destination to the west, the header entered on the east port (code 1).
- R6: The Y phase is legal only under all of these conditions:
  - the switch is in the destination column;
  - the switch is not the source row;
  - the switch lies strictly past the source y and no further than the destination y;
  - for a destination to the south (larger y), the header entered on the north port (code 0);
  - for a destination to the north, the header entered on the south port (code 2).
  
  A header that meets neither R5 nor R6 (nor R4) sets distract_o one cycle later.
- R7: A header carrying an arrival port code of 5, 6 or 7 is always flagged as distracted.
- R8: alarm_valid_o is 1 for exactly the one cycle after a faulty header, and alarm_port_o then holds the arrival port code. Otherwise alarm_port_o is 0.
- R9: In a cycle after one with hdr_valid_i low, all outputs are zero, whatever hdr_i and in_port_i carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| here_x_i | input | COORD_W | Column of this switch |
| here_y_i | input | COORD_W | Row of this switch |
| hdr_valid_i | input | 1 | hdr_i holds a header flit this cycle |
| in_port_i | input | 3 | Arrival port: 0 north, 1 east, 2 south, 3 west, 4 local |
| hdr_i | input | FLIT_W | Header flit |
| hop_o | output | HOP_W | Updated hop count for the forwarded header |
| hop_valid_o | output | 1 | hop_o is valid |
| distract_o | output | 1 | Header could not legally be here |
| overflow_o | output | 1 | Hop count overflowed |
| alarm_valid_o | output | 1 | Single-cycle fault alarm |
| alarm_port_o | output | 3 | Arrival port of the faulty header |

## Verification
The bench uses the default parameters: 4-bit coordinates, a 6-bit hop field and a 32-bit flit. These put the full 16x16 mesh within reach, including the corner rows and columns. They also let a directed header with a hop count of 62 or 63 reach the overflow edge without sending a packet around a long loop. The reference model decides path membership independently of the RTL's rules: it walks the X-then-Y route hop by hop from source to destination and records the arrival port at each switch. Random headers drawn from a small corner of the mesh make on-path and off-path cases both frequent.

// File: rtl/msc_pkg.sv
package msc_pkg;
  typedef enum logic [2:0] {
    PORT_N = 3'd0,
    PORT_E = 3'd1,
    PORT_S = 3'd2,
    PORT_W = 3'd3,
    PORT_L = 3'd4
  } port_e;
endpackage

// File: rtl/msc_axis_seg.sv
// Legal arrival test for one dimension of the dimension-ordered route.
module msc_axis_seg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] here_i,
  input  logic [W-1:0] from_i,
  input  logic [W-1:0] to_i,
  input  logic         lane_ok_i,   // other-axis coordinate matches this phase
  input  logic [2:0]   port_i,
  input  logic [2:0]   port_up_i,   // arrival port when moving to larger coord
  input  logic [2:0]   port_dn_i,   // arrival port when moving to smaller coord
  output logic         ok_o
);
  logic up;
  logic in_up;
  logic in_dn;

  always_comb begin
    up    = to_i > from_i;
    in_up = (here_i > from_i) && (here_i <= to_i) && (port_i == port_up_i);
    in_dn = (here_i < from_i) && (here_i >= to_i) && (port_i == port_dn_i);
    ok_o  = lane_ok_i && (here_i != from_i) && (up ? in_up : in_dn);
  end
endmodule

// File: rtl/msc_hop_inc.sv
module msc_hop_inc #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] hop_i,
  output logic [W-1:0] hop_o,
  output logic         ovf_o
);
  logic [W-1:0] sum;

  always_comb begin
    {ovf_o, sum} = {1'b0, hop_i} + {{W{1'b0}}, 1'b1};
    hop_o = ovf_o ? {W{1'b1}} : sum;
  end
endmodule

// File: rtl/misroute_hop_checker.sv
module misroute_hop_checker
  import msc_pkg::*;
#(
  parameter int unsigned COORD_W = 4,
  parameter int unsigned HOP_W   = 6,
  parameter int unsigned FLIT_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [COORD_W-1:0] here_x_i,
  input  logic [COORD_W-1:0] here_y_i,
  input  logic               hdr_valid_i,
  input  logic [2:0]         in_port_i,
  input  logic [FLIT_W-1:0]  hdr_i,
  output logic [HOP_W-1:0]   hop_o,
  output logic               hop_valid_o,
  output logic               distract_o,
  output logic               overflow_o,
  output logic               alarm_valid_o,
  output logic [2:0]         alarm_port_o
);
  localparam int unsigned DX_LO  = 0;
  localparam int unsigned DY_LO  = COORD_W;
  localparam int unsigned SX_LO  = 2 * COORD_W;
  localparam int unsigned SY_LO  = 3 * COORD_W;
  localparam int unsigned HOP_LO = 4 * COORD_W;
  localparam int unsigned NAXIS  = 2;

  logic [COORD_W-1:0] dst_x, dst_y, src_x, src_y;
  logic [HOP_W-1:0]   hop_in, hop_nxt;
  logic               hop_ovf;
  logic               local_ok, on_path, err;

  always_comb begin
    dst_x  = hdr_i[DX_LO  +: COORD_W];
    dst_y  = hdr_i[DY_LO  +: COORD_W];
    src_x  = hdr_i[SX_LO  +: COORD_W];
    src_y  = hdr_i[SY_LO  +: COORD_W];
    hop_in = hdr_i[HOP_LO +: HOP_W];
  end

  // axis 0: X phase in source row; axis 1: Y phase in destination column
  logic [COORD_W-1:0] ax_here [NAXIS];
  logic [COORD_W-1:0] ax_from [NAXIS];
  logic [COORD_W-1:0] ax_to   [NAXIS];
  logic               ax_lane [NAXIS];
  logic [2:0]         ax_pup  [NAXIS];
  logic [2:0]         ax_pdn  [NAXIS];
  logic [NAXIS-1:0]   ax_ok;

  always_comb begin
    ax_here[0] = here_x_i; ax_from[0] = src_x; ax_to[0] = dst_x;
    ax_lane[0] = (here_y_i == src_y);
    ax_pup[0]  = PORT_W;   ax_pdn[0]  = PORT_E;
    ax_here[1] = here_y_i; ax_from[1] = src_y; ax_to[1] = dst_y;
    ax_lane[1] = (here_x_i == dst_x);
    ax_pup[1]  = PORT_N;   ax_pdn[1]  = PORT_S;
  end

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    msc_axis_seg #(.W(COORD_W)) u_seg (
      .here_i    (ax_here[a]),
      .from_i    (ax_from[a]),
      .to_i      (ax_to[a]),
      .lane_ok_i (ax_lane[a]),
      .port_i    (in_port_i),
      .port_up_i (ax_pup[a]),
      .port_dn_i (ax_pdn[a]),
      .ok_o      (ax_ok[a])
    );
  end

  msc_hop_inc #(.W(HOP_W)) u_hop (
    .hop_i (hop_in),
    .hop_o (hop_nxt),
    .ovf_o (hop_ovf)
  );

  always_comb begin
    local_ok = (in_port_i == PORT_L) && (here_x_i == src_x) && (here_y_i == src_y);
    on_path  = local_ok || (|ax_ok);
    err      = !on_path || hop_ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hop_o         <= '0;
      hop_valid_o   <= 1'b0;
      distract_o    <= 1'b0;
      overflow_o    <= 1'b0;
      alarm_valid_o <= 1'b0;
      alarm_port_o  <= '0;
    end else begin
      hop_o         <= hdr_valid_i ? hop_nxt : '0;
      hop_valid_o   <= hdr_valid_i;
      distract_o    <= hdr_valid_i && !on_path;
      overflow_o    <= hdr_valid_i && hop_ovf;
      alarm_valid_o <= hdr_valid_i && err;
      alarm_port_o  <= (hdr_valid_i && err) ? in_port_i : 3'd0;
    end
  end
endmodule

// File: rtl/msc_sva.sv
module msc_sva #(
  parameter int unsigned COORD_W = 4,
  parameter int unsigned HOP_W   = 6,
  parameter int unsigned FLIT_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [COORD_W-1:0] here_x_i,
  input logic [COORD_W-1:0] here_y_i,
  input logic               hdr_valid_i,
  input logic [2:0]         in_port_i,
  input logic [FLIT_W-1:0]  hdr_i,
  input logic [HOP_W-1:0]   hop_o,
  input logic               hop_valid_o,
  input logic               distract_o,
  input logic               overflow_o,
  input logic               alarm_valid_o,
  input logic [2:0]         alarm_port_o
);
  localparam int unsigned HOP_LO = 4 * COORD_W;
  logic [HOP_W-1:0] hop_f;
  logic             src_here;
  assign hop_f    = hdr_i[HOP_LO +: HOP_W];
  assign src_here = (hdr_i[2*COORD_W +: COORD_W] == here_x_i) &&
                    (hdr_i[3*COORD_W +: COORD_W] == here_y_i);

  AST_HOP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && (hop_f != {HOP_W{1'b1}}) |=> hop_valid_o && !overflow_o && (hop_o == $past(hop_f) + 1'b1)); // R2
  AST_HOP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && (hop_f == {HOP_W{1'b1}}) |=> overflow_o && alarm_valid_o && (hop_o == {HOP_W{1'b1}})); // R3
  AST_LOCAL_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && (in_port_i == 3'd4) |=> (distract_o != $past(src_here))); // R4
  AST_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && (in_port_i > 3'd4) |=> distract_o); // R7
  AST_ALARM_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_valid_o |-> (alarm_port_o == $past(in_port_i)) && (distract_o || overflow_o)); // R8
  AST_ALARM_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_valid_o && !hdr_valid_i |=> !alarm_valid_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_valid_i |=> !hop_valid_o && !alarm_valid_o && !distract_o && (hop_o == '0)); // R9
endmodule

bind misroute_hop_checker msc_sva #(
  .COORD_W(COORD_W), .HOP_W(HOP_W), .FLIT_W(FLIT_W)
) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .here_x_i(here_x_i), .here_y_i(here_y_i),
  .hdr_valid_i(hdr_valid_i), .in_port_i(in_port_i), .hdr_i(hdr_i),
  .hop_o(hop_o), .hop_valid_o(hop_valid_o), .distract_o(distract_o),
  .overflow_o(overflow_o), .alarm_valid_o(alarm_valid_o), .alarm_port_o(alarm_port_o)
);

// File: tb/tb_misroute_hop_checker.sv
module tb_misroute_hop_checker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hx = '0, hy = '0;
  logic        hv = 1'b0;
  logic [2:0]  port = '0;
  logic [31:0] hdr = '0;
  logic [5:0]  hop_o;
  logic        hop_valid_o, distract_o, overflow_o, alarm_valid_o;
  logic [2:0]  alarm_port_o;

  int n_cmp = 0, n_bad = 0;
  bit pend = 0;
  int e_hop, e_hv, e_dist, e_ovf, e_al, e_ap;
  string e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  misroute_hop_checker dut (
    .clk_i(clk), .rst_ni(rst_n), .here_x_i(hx), .here_y_i(hy),
    .hdr_valid_i(hv), .in_port_i(port), .hdr_i(hdr),
    .hop_o(hop_o), .hop_valid_o(hop_valid_o), .distract_o(distract_o),
    .overflow_o(overflow_o), .alarm_valid_o(alarm_valid_o), .alarm_port_o(alarm_port_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Walks the X-then-Y route, noting arrival port at each switch.
  function automatic bit ref_on_path(int cx, int cy, int sx, int sy, int dx, int dy, int p);
    int x = sx, y = sy;
    if (p == 4) return (cx == sx) && (cy == sy);
    while (x != dx) begin
      int ap;
      if (dx > x) begin x++; ap = 3; end else begin x--; ap = 1; end
      if (x == cx && y == cy && ap == p) return 1;
    end
    while (y != dy) begin
      int ap;
      if (dy > y) begin y++; ap = 0; end else begin y--; ap = 2; end
      if (x == cx && y == cy && ap == p) return 1;
    end
    return 0;
  endfunction

  task automatic compare();
    string t_hop, t_al;
    if (!pend) return;
    t_hop = (e_ovf != 0) ? "R3" : "R2";
    t_al  = "R8";
    if (e_hv == 0) begin e_tag = "R9"; t_hop = "R9"; t_al = "R9"; end
    chk(t_hop, "hop_o", int'(hop_o), e_hop);
    chk(t_hop, "hop_valid_o", int'(hop_valid_o), e_hv);
    chk(e_tag, "distract_o", int'(distract_o), e_dist);
    chk(t_hop, "overflow_o", int'(overflow_o), e_ovf);
    chk(t_al, "alarm_valid_o", int'(alarm_valid_o), e_al);
    chk(t_al, "alarm_port_o", int'(alarm_port_o), e_ap);
  endtask

  task automatic step(bit v, int p, int cx, int cy, int sx, int sy, int dx, int dy, int h, string tag);
    bit on;
    @(negedge clk);
    compare();
    hv = v; port = 3'(p); hx = 4'(cx); hy = 4'(cy);
    hdr = {10'h0, 6'(h), 4'(sy), 4'(sx), 4'(dy), 4'(dx)};
    on = ref_on_path(cx, cy, sx, sy, dx, dy, p);
    e_hv   = v;
    e_ovf  = v && (h == 63);
    e_hop  = !v ? 0 : (h == 63 ? 63 : h + 1);
    e_dist = v && !on;
    e_al   = (e_dist != 0) || (e_ovf != 0);
    e_ap   = e_al ? p : 0;
    e_tag  = tag;
    pend   = 1;
  endtask

  initial begin : wd
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "hop_valid_o", int'(hop_valid_o), 0);
    chk("R1", "alarm_valid_o", int'(alarm_valid_o), 0);
    chk("R1", "hop_o", int'(hop_o), 0);
    chk("R1", "distract_o", int'(distract_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "alarm_port_o", int'(alarm_port_o), 0);

    // R4 local injection
    step(1, 4, 5, 5, 5, 5, 9, 1, 0, "R4");
    step(1, 4, 5, 5, 4, 5, 9, 1, 7, "R4");
    // R5 X phase
    step(1, 3, 5, 5, 2, 5, 9, 1, 3, "R5");
    step(1, 1, 5, 5, 2, 5, 9, 1, 3, "R5");
    step(1, 1, 5, 5, 8, 5, 5, 9, 3, "R5");
    step(1, 3, 5, 5, 0, 5, 3, 5, 3, "R5");
    step(1, 0, 5, 5, 5, 5, 5, 5, 1, "R5");
    step(1, 3, 15, 0, 0, 0, 15, 15, 1, "R5");
    // R6 Y phase
    step(1, 0, 5, 5, 1, 2, 5, 9, 4, "R6");
    step(1, 3, 5, 5, 1, 2, 5, 9, 4, "R6");
    step(1, 2, 5, 5, 5, 9, 5, 0, 4, "R6");
    step(1, 0, 5, 5, 5, 9, 5, 0, 4, "R6");
    step(1, 0, 0, 15, 0, 0, 0, 15, 4, "R6");
    // R7 bad port codes
    step(1, 5, 5, 5, 5, 5, 9, 1, 0, "R7");
    step(1, 7, 5, 5, 2, 5, 9, 1, 0, "R7");
    // R3 overflow edge, on-path header
    step(1, 3, 5, 5, 2, 5, 9, 1, 62, "R3");
    step(1, 3, 5, 5, 2, 5, 9, 1, 63, "R3");
    step(1, 3, 5, 5, 2, 5, 9, 1, 63, "R3");
    // R9 idle with junk on the inputs
    step(0, 6, 5, 5, 1, 1, 1, 1, 63, "R9");
    step(0, 4, 3, 3, 3, 3, 3, 3, 63, "R9");
    // R8 back-to-back faults then clean header
    step(1, 2, 5, 5, 0, 0, 9, 9, 0, "R8");
    step(1, 3, 5, 5, 2, 5, 9, 1, 0, "R8");

    for (int i = 0; i < 4000; i++) begin
      int m = (i % 2 == 0) ? 3 : 15;
      int p = $urandom_range(0, 5);
      step(($urandom_range(0, 7) != 0), p,
           $urandom & m, $urandom & m, $urandom & m, $urandom & m,
           $urandom & m, $urandom & m,
           ($urandom_range(0, 15) == 0) ? 63 : $urandom_range(0, 62),
           (p == 4) ? "R4" : (p == 5) ? "R7" : "R6");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    @(negedge clk);
    compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule